// File: doc/BRIEF.md
# Dual-Line Interrupt Flag Controller

This block collects up to 32 event inputs into sticky status flags and presents them as two interrupt outputs. A flag is set when its event input goes from low to high. Holding the event high does not set the flag again. Once set, a flag stays set until the host clears it by writing a 1 to that flag's bit.

Three registers decide how flags reach the outputs. A per-flag enable register picks which flags may interrupt. A per-flag steering register sends each enabled flag to output line 0 or line 1. A two-bit line-enable register switches each output line on or off. Software uses a small synchronous register port to read and write the flag, enable, steering and line-enable registers.

Top module: `dual_line_irq_ctrl`

## Requirements
- R1: When event bit i is sampled low at one rising clock edge and high at the next edge k, flag bit i reads 1 after edge k+1.
- R2: Writing to address 0 clears every flag bit whose write-data bit is 1.
- R3: Writing to address 0 leaves unchanged every flag bit whose write-data bit is 0.
- R4: While the asynchronous active-low reset is asserted, and after it is released, flags, enables, steering bits and line enables are all 0, and both interrupt outputs are low.
- R5: A set flag whose bit in the enable register (address 1) is 0 drives neither interrupt line. The flag itself stays readable.
- R6: An enabled, set flag drives line 0 when its steering bit (address 2) is 0, and line 1 when the steering bit is 1.
- R7: Line n (bit n of `irq_o`) can be high only while bit n of the line-enable register (address 3, bits 1:0) is 1.
- R8: If a rising event edge and a host clear hit the same flag bit in the same cycle, the flag ends up set.
- R9: An event held high over many cycles sets its flag only once. After the host clears that flag, it stays clear until the event falls and rises again.
- R10: Reads return the flags at address 0, enables at address 1, steering at address 2, and the line enables in bits 1:0 of address 3 with the upper bits 0. Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Event inputs, one per flag |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| irq_o | output | 2 | Interrupt lines 0 and 1 |

## Verification
Events are tried as one-cycle pulses, as long-held levels, and as edges that arrive in the same cycle as a clear of the same bit. Pulses check the set timing. Held levels show whether detection works on edges or on levels. The collision case shows which side takes priority. The routing function is tried with flags on both steering values while the enable mask and each line enable are switched in turn. This separates masking by flag, steering to a line, and gating per line. A mid-run reset checks that all state returns to zero.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned ADDR_W    = 2;
  localparam int unsigned NUM_LINES = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_FLAG = 2'd0,
    REG_EN   = 2'd1,
    REG_SEL  = 2'd2,
    REG_LINE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/intc_edge_det.sv
module intc_edge_det #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] evt_q, evt_d;
  logic [W-1:0] prev_q, prev_d;

  always_comb begin
    evt_d  = evt_i;
    prev_d = evt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      prev_q <= '0;
    end else begin
      evt_q  <= evt_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = evt_q & ~prev_q;
endmodule

// File: rtl/intc_flag_bank.sv
module intc_flag_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q, flag_d;
  logic         upd;

  always_comb begin
    upd    = (|set_i) | (|clr_i);
    flag_d = (flag_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= '0;
    else if (upd) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
  import intc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [W-1:0]         wdata_i,
  output logic [W-1:0]         en_o,
  output logic [W-1:0]         sel_o,
  output logic [NUM_LINES-1:0] line_en_o
);
  logic [W-1:0]         en_q, en_d, sel_q, sel_d;
  logic [NUM_LINES-1:0] line_q, line_d;
  logic                 en_we, sel_we, line_we;

  always_comb begin
    en_we   = we_i && (addr_i == REG_EN);
    sel_we  = we_i && (addr_i == REG_SEL);
    line_we = we_i && (addr_i == REG_LINE);
    en_d    = wdata_i;
    sel_d   = wdata_i;
    line_d  = wdata_i[NUM_LINES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      sel_q  <= '0;
      line_q <= '0;
    end else begin
      if (en_we)   en_q   <= en_d;
      if (sel_we)  sel_q  <= sel_d;
      if (line_we) line_q <= line_d;
    end
  end

  assign en_o      = en_q;
  assign sel_o     = sel_q;
  assign line_en_o = line_q;
endmodule

// File: rtl/intc_route.sv
module intc_route
  import intc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]         flag_i,
  input  logic [W-1:0]         en_i,
  input  logic [W-1:0]         sel_i,
  input  logic [NUM_LINES-1:0] line_en_i,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [W-1:0] active;

  assign active = flag_i & en_i;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [W-1:0] steer;
    assign steer    = (l == 0) ? ~sel_i : sel_i;
    assign irq_o[l] = line_en_i[l] & (|(active & steer));
  end
endmodule

// File: rtl/dual_line_irq_ctrl.sv
module dual_line_irq_ctrl
  import intc_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] evt_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [NUM_FLAGS-1:0] reg_wdata_i,
  output logic [NUM_FLAGS-1:0] reg_rdata_o,
  output logic [NUM_LINES-1:0] irq_o
);
  logic                 rst_sync_n;
  logic [NUM_FLAGS-1:0] rise, clr, flag, en, sel;
  logic [NUM_LINES-1:0] line_en;

  intc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  intc_edge_det #(.W(NUM_FLAGS)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .evt_i(evt_i), .rise_o(rise));

  assign clr = (reg_we_i && reg_addr_i == REG_FLAG) ? reg_wdata_i : '0;

  intc_flag_bank #(.W(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .set_i(rise), .clr_i(clr), .flag_o(flag));

  intc_cfg_regs #(.W(NUM_FLAGS)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .en_o(en), .sel_o(sel), .line_en_o(line_en));

  intc_route #(.W(NUM_FLAGS)) u_route (
    .flag_i(flag), .en_i(en), .sel_i(sel), .line_en_i(line_en), .irq_o(irq_o));

  always_comb begin
    unique case (reg_addr_i)
      REG_FLAG: reg_rdata_o = flag;
      REG_EN:   reg_rdata_o = en;
      REG_SEL:  reg_rdata_o = sel;
      default:  reg_rdata_o = {{(NUM_FLAGS-NUM_LINES){1'b0}}, line_en};
    endcase
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] rise,
  input logic [W-1:0] clr,
  input logic [W-1:0] flag,
  input logic [1:0]   line_en,
  input logic [1:0]   irq
);
  // R1: a flag bit may only become set after a detected rising edge
  a_r1_set_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & ~$past(flag) & ~$past(rise)) == '0));

  // R3: a flag bit may only fall after a host clear of that bit
  a_r3_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag) & ~flag & ~$past(clr)) == '0));

  // R8: edge together with clear leaves the flag set
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(rise) & $past(clr) & ~flag) == '0));

  // R7: line n is gated by its line enable
  a_r7_line_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~line_en) == 2'b00));

  // R5: no interrupt without some set flag
  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != 2'b00) |-> (flag != '0));
endmodule

bind dual_line_irq_ctrl intc_checker #(.W(NUM_FLAGS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .rise(rise), .clr(clr), .flag(flag),
  .line_en(line_en), .irq(irq_o));

// File: tb/test_dual_line_irq_ctrl.sv
module test_dual_line_irq_ctrl;
  logic        clk;
  logic        rst_n;
  logic [31:0] evt_i;
  logic        reg_we_i;
  logic [1:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic [1:0]  irq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    string       req;
    logic [31:0] exp_data;
    logic [1:0]  exp_irq;
  } item_t;
  item_t sb[$];

  dual_line_irq_ctrl i_dual_line_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we_i(reg_we_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired: actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (reg_rdata_o !== it.exp_data || irq_o !== it.exp_irq) begin
        errors++;
        $display("FAIL %s: actual data %h irq %b expected data %h irq %b",
                 it.req, reg_rdata_o, irq_o, it.exp_data, it.exp_irq);
      end
    end
  end

  task automatic sample(input logic [1:0] a, input logic [31:0] d,
                        input logic [1:0] q, input string req);
    item_t it;
    @(posedge clk); #1;
    reg_we_i   = 1'b0;
    reg_addr_i = a;
    it.req = req; it.exp_data = d; it.exp_irq = q;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk); #1;
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    evt_i = '0; reg_we_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
    do_reset();

    // R4 reset state
    sample(2'd0, 32'h0, 2'b00, "R4 flags after reset");
    sample(2'd3, 32'h0, 2'b00, "R4 line enables after reset");

    // configuration and readback
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'hFFFF_0000);
    wr(2'd3, 32'hFFFF_FFFF);
    sample(2'd1, 32'hFFFF_FFFF, 2'b00, "R10 enable readback");
    sample(2'd2, 32'hFFFF_0000, 2'b00, "R10 steering readback");
    sample(2'd3, 32'h0000_0003, 2'b00, "R10 line enable upper bits zero");

    // R1 / R6 pulse on bit 3 -> line 0
    @(posedge clk); #1 evt_i[3] = 1'b1;
    @(posedge clk); #1 evt_i[3] = 1'b0;
    sample(2'd0, 32'h0000_0008, 2'b01, "R1 R6 pulse bit3 on line 0");

    // R9 held-high event, clear, remain clear
    @(posedge clk); #1 evt_i[7] = 1'b1;
    @(posedge clk);
    sample(2'd0, 32'h0000_0088, 2'b01, "R9 held event sets flag");
    wr(2'd0, 32'h0000_0080);
    repeat (4) @(posedge clk);
    sample(2'd0, 32'h0000_0008, 2'b01, "R9 held event does not re-set");
    #1 evt_i[7] = 1'b0;

    // R6 bit 20 -> line 1
    @(posedge clk); #1 evt_i[20] = 1'b1;
    @(posedge clk); #1 evt_i[20] = 1'b0;
    sample(2'd0, 32'h0010_0008, 2'b11, "R6 bit20 on line 1");

    // R3 write of zeros
    wr(2'd0, 32'h0000_0000);
    sample(2'd0, 32'h0010_0008, 2'b11, "R3 zero write keeps flags");

    // R2 clear bit 3
    wr(2'd0, 32'h0000_0008);
    sample(2'd0, 32'h0010_0000, 2'b10, "R2 clear bit3");

    // R5 mask bit 20
    wr(2'd1, 32'hFFEF_FFFF);
    sample(2'd0, 32'h0010_0000, 2'b00, "R5 masked flag no irq");
    wr(2'd1, 32'hFFFF_FFFF);

    // R7 line enables
    wr(2'd3, 32'h0000_0001);
    sample(2'd0, 32'h0010_0000, 2'b00, "R7 line1 disabled");
    wr(2'd3, 32'h0000_0002);
    sample(2'd0, 32'h0010_0000, 2'b10, "R7 line1 enabled");
    wr(2'd0, 32'h0010_0000);
    sample(2'd0, 32'h0000_0000, 2'b00, "R2 clear bit20");

    // R8 edge and clear in the same cycle on bit 5
    @(posedge clk); #1 evt_i[5] = 1'b1;
    @(posedge clk); #1;                  // evt registered, edge now active
    reg_we_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 32'h0000_0020;
    @(posedge clk); #1;                  // set and clear collide here
    reg_we_i = 1'b0; reg_wdata_i = '0; evt_i[5] = 1'b0;
    sample(2'd0, 32'h0000_0020, 2'b00, "R8 set wins over clear");
    wr(2'd3, 32'h0000_0001);
    sample(2'd0, 32'h0000_0020, 2'b01, "R6 R8 bit5 on line 0");

    // R4 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    sample(2'd0, 32'h0, 2'b00, "R4 flags during reset");
    do_reset();
    sample(2'd1, 32'h0, 2'b00, "R4 enables cleared");
    sample(2'd2, 32'h0, 2'b00, "R4 steering cleared");

    repeat (2) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule